// File: doc/BRIEF.md
# Byte-Stream SPI Master with Transmit and Receive Queues

This block is a memory-mapped SPI master. Software talks to it through a 32-bit register port that is addressed in words. Bytes written to the transmit data register go into a transmit queue. While the master-hold bit in the control register is clear, the block takes one byte at a time from that queue and shifts it out on the serial lines. Each byte that comes back from the slave is appended to a receive queue, and software reads it from the receive data register. Each queue holds 256 bytes.

A status register reports whether each queue is empty or full. Two occupancy registers report how far each queue is filled. A select register drives active-low chip-select pins directly. A soft-reset register returns the whole block to its reset state, but only when a key value is written to it.

The block does not combine interrupts itself. It emits one-cycle event pulses to a separate interrupt controller:

- one per completed byte, for "transmit side drained";
- one per completed byte, for "receive data present";
- one when the receive queue becomes full;
- one when a received byte is lost because the queue was already full.

Top module: `spim_fifo_ctrl`

## Requirements
- R1: After reset the status register (word 0x19) reads 0x5, the control register (word 0x18) reads 0, the select register (word 0x1C) reads 0xFFFFFFFF and every cs_n pin is high.
- R2: Status bit 0 means the receive queue is empty, bit 1 that it is full, bit 2 that the transmit queue is empty and bit 3 that it is full. All other status bits read 0. A write to the status register changes nothing.
- R3: Writing control bit 5 empties the transmit queue and writing control bit 6 empties the receive queue. Both bits read back as 0. Every other written control bit is stored and reads back unchanged.
- R4: While control bit 8 (master hold) is 1, bytes written to the transmit data register (word 0x1A) only wait in the queue and sclk does not toggle. Once the bit is 0, the queue drains until it is empty.
- R5: Transfers use SPI mode 0. sclk idles low, each byte goes out MSB first with mosi stable while sclk is high, and miso is sampled on rising sclk. A byte finishes all 8 clocks before the next byte leaves the queue.
- R6: Each byte received from the slave is appended to the receive queue. Reading the receive data register (word 0x1B) removes the oldest byte and returns it in bits 7:0 with bits 31:8 at 0, in the order the bytes arrived.
- R7: A byte that arrives while the receive queue holds 256 bytes is dropped and evt_rx_overrun pulses for one cycle. A byte that brings the queue to 256 makes evt_rx_full pulse for one cycle.
- R8: Each completed byte makes evt_tx_empty and evt_rx_not_empty pulse for one cycle.
- R9: Reading the receive data register while the receive queue is empty returns 0xDEADBEEF and leaves the queue and the status unchanged.
- R10: Writing 0x0000000A to the soft-reset register (word 0x10) clears the control register, empties both queues and sets the select register to all ones. Any other value written there has no effect.
- R11: Pin cs_n[i] always equals bit i of the select register, so a 0 in that bit selects slave i.
- R12: The occupancy registers (transmit at word 0x1D, receive at word 0x1E) read the byte count minus one, and 0 when the queue is empty.
- R13: A byte written to the transmit data register while the transmit queue holds 256 bytes is discarded.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access strobe, one access per cycle |
| bus_wr | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | 5 | Word index of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the same cycle as the strobe |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data to the slave |
| miso | input | 1 | Serial data from the slave |
| cs_n | output | NUM_CS | Active-low chip selects |
| evt_tx_empty | output | 1 | Pulse per completed byte (transmit side drained) |
| evt_rx_not_empty | output | 1 | Pulse per completed byte (receive data present) |
| evt_rx_full | output | 1 | Pulse when the receive queue becomes full |
| evt_rx_overrun | output | 1 | Pulse when a received byte is dropped |

## Verification
The hardest state to reach from the ports is a receive queue that is already full when one more byte arrives.

To get there, the bench sets the master-hold bit and queues 256 transmit bytes. It then writes a 257th byte to confirm that a full transmit queue drops it. Next it releases the hold, so all 256 bytes loop back through a bench slave and fill the receive queue without a single read. Only after that does it send one more byte to provoke the overrun. Draining all 256 bytes afterwards shows that the order was kept and that the dropped byte never entered the queue.

// File: rtl/spim_pkg.sv
`timescale 1ns/1ps
package spim_pkg;
  localparam logic [4:0]  ADDR_SOFTRST = 5'h10;
  localparam logic [4:0]  ADDR_CTRL    = 5'h18;
  localparam logic [4:0]  ADDR_STAT    = 5'h19;
  localparam logic [4:0]  ADDR_TXDATA  = 5'h1A;
  localparam logic [4:0]  ADDR_RXDATA  = 5'h1B;
  localparam logic [4:0]  ADDR_SSEL    = 5'h1C;
  localparam logic [4:0]  ADDR_TXOCC   = 5'h1D;
  localparam logic [4:0]  ADDR_RXOCC   = 5'h1E;

  localparam logic [31:0] SOFTRST_KEY  = 32'h0000_000A;
  localparam logic [31:0] EMPTY_MARK   = 32'hDEAD_BEEF;

  localparam int          CTRL_TXCLR   = 5;
  localparam int          CTRL_RXCLR   = 6;
  localparam int          CTRL_HOLD    = 8;
  localparam logic [31:0] CTRL_KEEP    = ~((32'd1 << CTRL_TXCLR) | (32'd1 << CTRL_RXCLR));

  localparam int          XFER_BITS    = 8;

  typedef enum logic {SH_IDLE, SH_RUN} sh_state_e;
endpackage

// File: rtl/spim_fifo.sv
`timescale 1ns/1ps
module spim_fifo #(
  parameter  int DEPTH = 256,
  parameter  int WIDTH = 8,
  localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW    = $clog2(DEPTH) + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             push,
  input  logic             pop,
  input  logic [WIDTH-1:0] wdata,
  output logic [WIDTH-1:0] rdata,
  output logic [CW-1:0]    count,
  output logic             empty,
  output logic             full
);
  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wr_q, wr_d, rd_q, rd_d;
  logic [CW-1:0]    cnt_q, cnt_d;
  logic             do_push, do_pop;

  function automatic logic [AW-1:0] ptr_next(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign empty   = (cnt_q == '0);
  assign full    = (cnt_q == CW'(DEPTH));
  assign count   = cnt_q;
  assign rdata   = mem[rd_q];
  assign do_push = push && !full && !clr;
  assign do_pop  = pop && !empty && !clr;

  always_comb begin
    wr_d  = wr_q;
    rd_d  = rd_q;
    cnt_d = cnt_q;
    if (clr) begin
      wr_d  = '0;
      rd_d  = '0;
      cnt_d = '0;
    end else begin
      if (do_push) wr_d = ptr_next(wr_q);
      if (do_pop)  rd_d = ptr_next(rd_q);
      case ({do_push, do_pop})
        2'b10:   cnt_d = cnt_q + 1'b1;
        2'b01:   cnt_d = cnt_q - 1'b1;
        default: cnt_d = cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_q] <= wdata;
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (full && push && !pop && !clr) |=> (count == CW'(DEPTH))); // R13
  AST_EMPTY_POP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && pop && !push && !clr) |=> empty); // R9
endmodule

// File: rtl/spim_shifter.sv
`timescale 1ns/1ps
module spim_shifter
  import spim_pkg::*;
#(
  parameter  int CLK_DIV = 2,
  localparam int DW      = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1,
  localparam int HALVES  = 2 * XFER_BITS,
  localparam int EW      = $clog2(HALVES)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clr,
  input  logic                 start,
  input  logic [XFER_BITS-1:0] tx_byte,
  input  logic                 miso,
  output logic                 sclk,
  output logic                 mosi,
  output logic                 busy,
  output logic                 done,
  output logic [XFER_BITS-1:0] rx_byte
);
  sh_state_e            st_q, st_d;
  logic [DW-1:0]        div_q, div_d;
  logic [EW-1:0]        half_q, half_d;
  logic [XFER_BITS-1:0] sh_q, sh_d;
  logic                 samp_q, samp_d;
  logic                 sclk_q, sclk_d;
  logic                 done_q, done_d;
  logic                 tick;

  assign tick    = (div_q == DW'(CLK_DIV - 1));
  assign sclk    = sclk_q;
  assign mosi    = sh_q[XFER_BITS-1];
  assign busy    = (st_q == SH_RUN);
  assign done    = done_q;
  assign rx_byte = sh_q;

  always_comb begin
    st_d   = st_q;
    div_d  = div_q;
    half_d = half_q;
    sh_d   = sh_q;
    samp_d = samp_q;
    sclk_d = sclk_q;
    done_d = 1'b0;
    if (clr) begin
      st_d   = SH_IDLE;
      div_d  = '0;
      half_d = '0;
      sclk_d = 1'b0;
    end else begin
      case (st_q)
        SH_IDLE: begin
          if (start) begin
            sh_d   = tx_byte;
            st_d   = SH_RUN;
            div_d  = '0;
            half_d = '0;
            sclk_d = 1'b0;
          end
        end
        default: begin
          if (tick) begin
            div_d  = '0;
            sclk_d = !sclk_q;
            half_d = half_q + 1'b1;
            if (!sclk_q) begin
              samp_d = miso;
            end else begin
              sh_d = {sh_q[XFER_BITS-2:0], samp_q};
              if (half_q == EW'(HALVES - 1)) begin
                st_d   = SH_IDLE;
                done_d = 1'b1;
              end
            end
          end else begin
            div_d = div_q + 1'b1;
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= SH_IDLE;
      div_q  <= '0;
      half_q <= '0;
      sh_q   <= '0;
      samp_q <= 1'b0;
      sclk_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      div_q  <= div_d;
      half_q <= half_d;
      sh_q   <= sh_d;
      samp_q <= samp_d;
      sclk_q <= sclk_d;
      done_q <= done_d;
    end
  end

  AST_SCLK_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !sclk); // R5
  AST_MOSI_HELD_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    sclk |-> $stable(mosi)); // R5
endmodule

// File: rtl/spim_fifo_ctrl.sv
`timescale 1ns/1ps
module spim_fifo_ctrl
  import spim_pkg::*;
#(
  parameter  int NUM_CS     = 1,
  parameter  int FIFO_DEPTH = 256,
  parameter  int CLK_DIV    = 2,
  localparam int CW         = $clog2(FIFO_DEPTH) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [4:0]        bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              sclk,
  output logic              mosi,
  input  logic              miso,
  output logic [NUM_CS-1:0] cs_n,
  output logic              evt_tx_empty,
  output logic              evt_rx_not_empty,
  output logic              evt_rx_full,
  output logic              evt_rx_overrun
);
  logic [1:0]  rsync_q;
  logic        rst_i_n;
  logic [31:0] ctrl_q, ctrl_d, ss_q, ss_d;
  logic        wr_soft, wr_ctrl, wr_tx, wr_ss, rd_rx, soft_rst;
  logic        tx_clr, rx_clr, tx_empty, tx_full, rx_empty, rx_full;
  logic        rx_push, rx_pop, start, busy, xfer_done;
  logic [7:0]  tx_head, rx_head, rx_byte;
  logic [CW-1:0] tx_count, rx_count;
  logic [31:0] tx_occ, rx_occ;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_i_n = rsync_q[1];

  assign wr_soft  = bus_sel && bus_wr && (bus_addr == ADDR_SOFTRST);
  assign wr_ctrl  = bus_sel && bus_wr && (bus_addr == ADDR_CTRL);
  assign wr_tx    = bus_sel && bus_wr && (bus_addr == ADDR_TXDATA);
  assign wr_ss    = bus_sel && bus_wr && (bus_addr == ADDR_SSEL);
  assign rd_rx    = bus_sel && !bus_wr && (bus_addr == ADDR_RXDATA);
  assign soft_rst = wr_soft && (bus_wdata == SOFTRST_KEY);

  assign tx_clr   = soft_rst || (wr_ctrl && bus_wdata[CTRL_TXCLR]);
  assign rx_clr   = soft_rst || (wr_ctrl && bus_wdata[CTRL_RXCLR]);

  assign start    = !busy && !ctrl_q[CTRL_HOLD] && !tx_empty && !tx_clr;
  assign rx_push  = xfer_done && !rx_full && !rx_clr;
  assign rx_pop   = rd_rx && !rx_empty;

  always_comb begin
    ctrl_d = ctrl_q;
    ss_d   = ss_q;
    if (soft_rst) begin
      ctrl_d = '0;
      ss_d   = '1;
    end else begin
      if (wr_ctrl) ctrl_d = bus_wdata & CTRL_KEEP;
      if (wr_ss)   ss_d   = bus_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      ctrl_q <= '0;
      ss_q   <= '1;
    end else begin
      ctrl_q <= ctrl_d;
      ss_q   <= ss_d;
    end
  end

  assign cs_n = ss_q[NUM_CS-1:0];

  spim_fifo #(.DEPTH(FIFO_DEPTH), .WIDTH(8)) u_txq (
    .clk(clk), .rst_n(rst_i_n), .clr(tx_clr), .push(wr_tx), .pop(start),
    .wdata(bus_wdata[7:0]), .rdata(tx_head), .count(tx_count),
    .empty(tx_empty), .full(tx_full)
  );

  spim_fifo #(.DEPTH(FIFO_DEPTH), .WIDTH(8)) u_rxq (
    .clk(clk), .rst_n(rst_i_n), .clr(rx_clr), .push(rx_push), .pop(rx_pop),
    .wdata(rx_byte), .rdata(rx_head), .count(rx_count),
    .empty(rx_empty), .full(rx_full)
  );

  spim_shifter #(.CLK_DIV(CLK_DIV)) u_shift (
    .clk(clk), .rst_n(rst_i_n), .clr(soft_rst), .start(start), .tx_byte(tx_head),
    .miso(miso), .sclk(sclk), .mosi(mosi), .busy(busy), .done(xfer_done),
    .rx_byte(rx_byte)
  );

  assign evt_tx_empty     = xfer_done && !soft_rst;
  assign evt_rx_not_empty = xfer_done && !soft_rst;
  assign evt_rx_overrun   = xfer_done && rx_full && !rx_clr;
  assign evt_rx_full      = rx_push && !rx_pop && (rx_count == CW'(FIFO_DEPTH - 1));

  assign tx_occ = (tx_count == '0) ? '0 : 32'(tx_count) - 32'd1;
  assign rx_occ = (rx_count == '0) ? '0 : 32'(rx_count) - 32'd1;

  always_comb begin
    bus_rdata = '0;
    if (bus_sel && !bus_wr) begin
      case (bus_addr)
        ADDR_CTRL:   bus_rdata = ctrl_q;
        ADDR_STAT:   bus_rdata = {28'd0, tx_full, tx_empty, rx_full, rx_empty};
        ADDR_RXDATA: bus_rdata = rx_empty ? EMPTY_MARK : {24'd0, rx_head};
        ADDR_SSEL:   bus_rdata = ss_q;
        ADDR_TXOCC:  bus_rdata = tx_occ;
        ADDR_RXOCC:  bus_rdata = rx_occ;
        default:     bus_rdata = '0;
      endcase
    end
  end

  AST_HOLD_NO_START: assert property (@(posedge clk) disable iff (!rst_i_n)
    (ctrl_q[CTRL_HOLD] && !busy) |=> !busy); // R4
  AST_OVERRUN_QUEUE_FULL: assert property (@(posedge clk) disable iff (!rst_i_n)
    (evt_rx_overrun && !rx_pop) |=> (rx_count == CW'(FIFO_DEPTH))); // R7
  AST_EMPTY_READ_NO_CHANGE: assert property (@(posedge clk) disable iff (!rst_i_n)
    (rd_rx && rx_empty && !xfer_done) |=> rx_empty); // R9
endmodule

// File: tb/sim_spim_fifo_ctrl.sv
`timescale 1ns/1ps
module sim_spim_fifo_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_wr = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        sclk, mosi, miso;
  logic [1:0]  cs_n;
  logic        evt_tx_empty, evt_rx_not_empty, evt_rx_full, evt_rx_overrun;
  logic        inv = 1'b0;

  int n_chk = 0, n_fail = 0;
  int c_txe = 0, c_rxne = 0, c_full = 0, c_ovr = 0, edges = 0;
  logic [7:0] mon_sh = '0;

  always #10 clk = !clk;
  assign miso = mosi ^ inv;

  spim_fifo_ctrl #(.NUM_CS(2), .FIFO_DEPTH(256), .CLK_DIV(2)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .sclk(sclk), .mosi(mosi), .miso(miso), .cs_n(cs_n),
    .evt_tx_empty(evt_tx_empty), .evt_rx_not_empty(evt_rx_not_empty),
    .evt_rx_full(evt_rx_full), .evt_rx_overrun(evt_rx_overrun)
  );

  always @(negedge clk) begin
    if (evt_tx_empty)     c_txe++;
    if (evt_rx_not_empty) c_rxne++;
    if (evt_rx_full)      c_full++;
    if (evt_rx_overrun)   c_ovr++;
  end

  always @(posedge sclk) begin
    mon_sh = {mon_sh[6:0], mosi};
    edges++;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #5 d = bus_rdata;
    @(negedge clk);
    bus_sel = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [4:0] a, input logic [31:0] exp);
    logic [31:0] v;
    rd(a, v);
    chk(req, v, exp);
  endtask

  task automatic clear_counts();
    c_txe = 0; c_rxne = 0; c_full = 0; c_ovr = 0;
  endtask

  task automatic t_reset();
    rd_chk("R1 status", 5'h19, 32'h5);
    rd_chk("R1 ctrl", 5'h18, 32'h0);
    rd_chk("R1 select", 5'h1C, 32'hFFFF_FFFF);
    chk("R1 cs_n", {30'd0, cs_n}, 32'h3);
    rd_chk("R12 tx occ empty", 5'h1D, 32'h0);
    rd_chk("R12 rx occ empty", 5'h1E, 32'h0);
  endtask

  task automatic t_status_ro();
    wr(5'h19, 32'hFFFF_FFFF);
    rd_chk("R2 status write ignored", 5'h19, 32'h5);
  endtask

  task automatic t_single();
    int e0;
    clear_counts();
    inv = 1'b0;
    e0 = edges;
    wr(5'h1A, 32'h0000_00A5);
    repeat (60) @(negedge clk);
    chk("R5 mosi msb first", {24'd0, mon_sh}, 32'hA5);
    chk("R5 eight clocks", edges - e0, 8);
    chk("R8 tx empty events", c_txe, 1);
    chk("R8 rx not empty events", c_rxne, 1);
    rd_chk("R2 status one rx byte", 5'h19, 32'h4);
    rd_chk("R12 rx occ one", 5'h1E, 32'h0);
    rd_chk("R6 rx byte", 5'h1B, 32'hA5);
    rd_chk("R2 status after pop", 5'h19, 32'h5);
    rd_chk("R9 empty marker", 5'h1B, 32'hDEAD_BEEF);
    rd_chk("R9 status unchanged", 5'h19, 32'h5);
    rd_chk("R9 occ unchanged", 5'h1E, 32'h0);
  endtask

  task automatic t_hold();
    int e0;
    inv = 1'b1;
    wr(5'h18, 32'h100);
    e0 = edges;
    wr(5'h1A, 32'h12);
    wr(5'h1A, 32'h34);
    wr(5'h1A, 32'h56);
    repeat (150) @(negedge clk);
    chk("R4 no sclk while held", edges - e0, 0);
    rd_chk("R12 tx occ three", 5'h1D, 32'h2);
    rd_chk("R2 status tx queued", 5'h19, 32'h1);
    wr(5'h18, 32'h0);
    repeat (150) @(negedge clk);
    chk("R4 drained clocks", edges - e0, 24);
    rd_chk("R12 rx occ three", 5'h1E, 32'h2);
    rd_chk("R6 first", 5'h1B, 32'hED);
    rd_chk("R6 second", 5'h1B, 32'hCB);
    rd_chk("R6 third", 5'h1B, 32'hA9);
    inv = 1'b0;
  endtask

  task automatic t_queue_clear();
    int e0;
    wr(5'h1A, 32'h11);
    repeat (60) @(negedge clk);
    wr(5'h18, 32'h100);
    wr(5'h1A, 32'h22);
    wr(5'h1A, 32'h33);
    rd_chk("R2 both queues busy", 5'h19, 32'h0);
    wr(5'h18, 32'h160);
    rd_chk("R3 clear bits read 0", 5'h18, 32'h100);
    rd_chk("R3 queues emptied", 5'h19, 32'h5);
    rd_chk("R3 tx occ", 5'h1D, 32'h0);
    e0 = edges;
    wr(5'h18, 32'h0);
    repeat (60) @(negedge clk);
    chk("R3 cleared tx not sent", edges - e0, 0);
    wr(5'h18, 32'h0001_0003);
    rd_chk("R3 other bits stored", 5'h18, 32'h0001_0003);
    wr(5'h18, 32'h0);
  endtask

  task automatic t_overrun();
    logic [31:0] v;
    inv = 1'b0;
    wr(5'h18, 32'h100);
    for (int i = 0; i < 256; i++) wr(5'h1A, i);
    rd_chk("R2 tx full", 5'h19, 32'h9);
    wr(5'h1A, 32'h77);
    rd_chk("R13 tx drop when full", 5'h1D, 32'd255);
    clear_counts();
    wr(5'h18, 32'h0);
    repeat (9000) @(negedge clk);
    chk("R7 full event once", c_full, 1);
    chk("R7 no overrun yet", c_ovr, 0);
    chk("R8 event per byte", c_txe, 256);
    rd_chk("R2 rx full", 5'h19, 32'h6);
    wr(5'h1A, 32'hEE);
    repeat (60) @(negedge clk);
    chk("R7 overrun event", c_ovr, 1);
    rd_chk("R7 rx occ unchanged", 5'h1E, 32'd255);
    for (int i = 0; i < 256; i++) begin
      rd(5'h1B, v);
      chk("R6 ordered drain", v, i);
    end
    rd_chk("R7 empty after drain", 5'h19, 32'h5);
  endtask

  task automatic t_softrst();
    int e0;
    wr(5'h1C, 32'hFFFF_FFFE);
    chk("R11 cs0 selected", {30'd0, cs_n}, 32'h2);
    wr(5'h1C, 32'hFFFF_FFFD);
    chk("R11 cs1 selected", {30'd0, cs_n}, 32'h1);
    wr(5'h18, 32'h100);
    wr(5'h1A, 32'h5A);
    wr(5'h1A, 32'h5B);
    wr(5'h10, 32'h5);
    rd_chk("R10 wrong key ctrl", 5'h18, 32'h100);
    rd_chk("R10 wrong key select", 5'h1C, 32'hFFFF_FFFD);
    rd_chk("R10 wrong key tx occ", 5'h1D, 32'h1);
    e0 = edges;
    wr(5'h10, 32'hA);
    rd_chk("R10 ctrl cleared", 5'h18, 32'h0);
    rd_chk("R10 select ones", 5'h1C, 32'hFFFF_FFFF);
    chk("R11 cs deselected", {30'd0, cs_n}, 32'h3);
    rd_chk("R10 status", 5'h19, 32'h5);
    repeat (60) @(negedge clk);
    chk("R10 queue discarded", edges - e0, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    t_reset();
    t_status_ro();
    t_single();
    t_hold();
    t_queue_clear();
    t_overrun();
    t_softrst();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule